// File: doc/BRIEF.md
# Board Control Register Block

A small register peripheral that sits on a simple 32-bit register bus. A bus master sees a 64 KiB address window. At fixed offsets it can read a constant board identification word and the core clock frequency in hertz, which is set when the block is built. It can also write and read back a word that drives the board LEDs, and read the state of the board switches.

The switch pins come from outside the clock domain. They pass through a two-flop synchroniser before software can see them. Software can also ask for a system reset: it writes one exact magic value to a command offset. The block answers with a single-cycle pulse to an external reset controller.

Every offset not listed reads as zero, and writes to any offset other than the LED and command offsets are dropped. Read data is registered and appears one clock after the read strobe.

Top module: `board_ctl_regs`

## Requirements
- R1: A read at byte offset 0x0 returns the constant 0x09272011; writes there leave it unchanged.
- R2: A read at offset 0x4 returns the parameter CLK_HZ (default 10,000,000); writes there leave it unchanged.
- R3: A write at offset 0x8 stores the full 32-bit word. A read at 0x8 returns that word, and `led_out` shows it from the cycle after the write. No other access changes it.
- R4: A read at offset 0xC returns `sw_in`, zero-extended to 32 bits, as sampled through a two-flop synchroniser. The value read at clock edge k is the input sampled at edge k-2. Writes at 0xC are ignored.
- R5: A write of exactly 0x0000DEAD at offset 0x10 makes `sys_rst_req` high for exactly the one cycle after that write. A write of any other value at 0x10 leaves `sys_rst_req` low.
- R6: An active-low reset clears the LED word, the synchronised switch value, `bus_rdata` and `sys_rst_req` to zero. The frequency read keeps its value.
- R7: A read at any offset other than 0x0, 0x4, 0x8 and 0xC returns zero. This includes 0x10, misaligned offsets and offsets higher up in the window. Writes at offsets other than 0x8 and 0x10 change nothing.
- R8: `bus_rdata` holds the read result for exactly the cycle after a cycle with `bus_rd` high. It is zero after any cycle without a read. A read and a write in the same cycle at 0x8 return the word held before that write.
- R9: Decoding uses all ADDR_W bits of the offset (default 16, a 0x10000-byte window). An address that matches a register only in its low bits is treated as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe, one access per high cycle |
| bus_rd | input | 1 | Read strobe, one access per high cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_rd` |
| sw_in | input | SW_W | Asynchronous switch pins |
| led_out | output | 32 | Stored LED word |
| sys_rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The bench builds the block with CLK_HZ set to 25,000,000 and SW_W set to 12, not the defaults. This shows that the frequency word comes from the parameter and not from a fixed literal. It also lets a switch value reach bits above the low byte, so the zero-extension and the full synchroniser width can be seen at the port. ADDR_W stays at 16. That keeps offsets such as 0x1008 and 0xFFFC reachable, which alias a register only in their low bits.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam logic [31:0] BOARD_ID_WORD = 32'h0927_2011;
  localparam logic [31:0] RESET_KEY     = 32'h0000_DEAD;

  localparam int unsigned OFS_ID   = 32'h00;
  localparam int unsigned OFS_FREQ = 32'h04;
  localparam int unsigned OFS_LED  = 32'h08;
  localparam int unsigned OFS_SW   = 32'h0C;
  localparam int unsigned OFS_CMD  = 32'h10;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_ID   = 3'd1,
    SEL_FREQ = 3'd2,
    SEL_LED  = 3'd3,
    SEL_SW   = 3'd4,
    SEL_CMD  = 3'd5
  } reg_sel_e;

  // Map a full-width byte offset to a register; any other offset is unmapped.
  function automatic reg_sel_e decode_offset(input logic [31:0] ofs);
    reg_sel_e s;
    case (ofs)
      OFS_ID:   s = SEL_ID;
      OFS_FREQ: s = SEL_FREQ;
      OFS_LED:  s = SEL_LED;
      OFS_SW:   s = SEL_SW;
      OFS_CMD:  s = SEL_CMD;
      default:  s = SEL_NONE;
    endcase
    return s;
  endfunction

  // True only when the written word equals the reset key exactly.
  function automatic logic is_reset_key(input logic [31:0] w);
    return (w == RESET_KEY);
  endfunction

  // Value returned for a given selection; write-only and unmapped give zero.
  function automatic logic [31:0] read_value(input reg_sel_e   s,
                                             input logic [31:0] freq,
                                             input logic [31:0] led,
                                             input logic [31:0] sw);
    logic [31:0] v;
    case (s)
      SEL_ID:   v = BOARD_ID_WORD;
      SEL_FREQ: v = freq;
      SEL_LED:  v = led;
      SEL_SW:   v = sw;
      default:  v = 32'h0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/board_ctl_sync.sv
module board_ctl_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output reg_sel_e          sel,
  output logic              led_we,
  output logic              cmd_hit
);

  localparam int PAD_W = 32 - ADDR_W;

  logic [31:0] ofs_full;

  if (PAD_W > 0) begin : g_pad
    assign ofs_full = {{PAD_W{1'b0}}, bus_addr};
  end else begin : g_nopad
    assign ofs_full = bus_addr[31:0];
  end

  assign sel     = decode_offset(ofs_full);
  assign led_we  = bus_wr && (sel == SEL_LED);
  assign cmd_hit = bus_wr && (sel == SEL_CMD) && is_reset_key(bus_wdata);

endmodule

// File: rtl/board_ctl_rdmux.sv
module board_ctl_rdmux
  import board_ctl_pkg::*;
#(
  parameter int unsigned CLK_HZ = 10_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_rd,
  input  reg_sel_e    sel,
  input  logic [31:0] led_q,
  input  logic [31:0] sw_q,
  output logic [31:0] bus_rdata
);

  localparam logic [31:0] FREQ_WORD = CLK_HZ;

  logic [31:0] rd_next;

  assign rd_next = bus_rd ? read_value(sel, FREQ_WORD, led_q, sw_q) : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= 32'h0;
    else        bus_rdata <= rd_next;
  end

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          SW_W        = 8,
  parameter int          SYNC_STAGES = 2,
  parameter int unsigned CLK_HZ      = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [SW_W-1:0]   sw_in,
  output logic [31:0]       led_out,
  output logic              sys_rst_req
);

  localparam int SW_PAD = 32 - SW_W;

  reg_sel_e        sel;
  logic            led_we;
  logic            cmd_hit;
  logic [SW_W-1:0] sw_sync;
  logic [31:0]     sw_word;
  logic [31:0]     led_q;
  logic            req_q;

  board_ctl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .sel       (sel),
    .led_we    (led_we),
    .cmd_hit   (cmd_hit)
  );

  board_ctl_sync #(.W(SW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (sw_in),
    .dout  (sw_sync)
  );

  if (SW_PAD > 0) begin : g_swpad
    assign sw_word = {{SW_PAD{1'b0}}, sw_sync};
  end else begin : g_swfull
    assign sw_word = sw_sync[31:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= 32'h0;
    else if (led_we) led_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= cmd_hit;
  end

  board_ctl_rdmux #(.CLK_HZ(CLK_HZ)) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .sel       (sel),
    .led_q     (led_q),
    .sw_q      (sw_word),
    .bus_rdata (bus_rdata)
  );

  assign led_out     = led_q;
  assign sys_rst_req = req_q;

endmodule

// File: rtl/board_ctl_regs_chk.sv
module board_ctl_regs_chk #(
  parameter int          ADDR_W = 16,
  parameter int unsigned CLK_HZ = 10_000_000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic [31:0]       led_out,
  input logic              sys_rst_req,
  input logic              led_we,
  input logic              cmd_hit
);

  logic known;
  assign known = (bus_addr == ADDR_W'(0))  || (bus_addr == ADDR_W'(4)) ||
                 (bus_addr == ADDR_W'(8))  || (bus_addr == ADDR_W'(12));

  p_id_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(0)) |=> (bus_rdata == 32'h0927_2011));

  p_freq_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(4)) |=> (bus_rdata == 32'(CLK_HZ)));

  p_led_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    led_we |=> (led_out == $past(bus_wdata)));

  p_led_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !led_we |=> $stable(led_out));

  p_req_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(bus_wr && bus_addr == ADDR_W'(16) && bus_wdata == 32'h0000_DEAD));

  p_req_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> sys_rst_req);

  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !known) |=> (bus_rdata == 32'h0));

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == 32'h0));

endmodule

bind board_ctl_regs board_ctl_regs_chk #(.ADDR_W(ADDR_W), .CLK_HZ(CLK_HZ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_rd      (bus_rd),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .led_out     (led_out),
  .sys_rst_req (sys_rst_req),
  .led_we      (led_we),
  .cmd_hit     (cmd_hit)
);

// File: tb/board_ctl_regs_tb.sv
module board_ctl_regs_tb;

  localparam int  T      = 10;
  localparam int  AW     = 16;
  localparam int  SWW    = 12;
  localparam int  HZ     = 25_000_000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [SWW-1:0] sw_in = '0;
  logic [31:0]    led_out;
  logic           sys_rst_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  string phase = "R6 reset";

  always #(T/2) clk = ~clk;

  board_ctl_regs #(.ADDR_W(AW), .SW_W(SWW), .CLK_HZ(HZ)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sw_in(sw_in), .led_out(led_out), .sys_rst_req(sys_rst_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model: expected outputs after each edge.
  logic [31:0] m_led = 0, m_rdata = 0;
  logic        m_req = 0;
  logic [31:0] hist[$];

  always @(posedge clk) begin
    logic [31:0] sync_now;
    logic [31:0] nd;
    if (!rst_n) begin
      m_led = 0; m_rdata = 0; m_req = 0; hist.delete();
    end else begin
      sync_now = (hist.size() == 2) ? hist[0] : 32'h0;
      nd = 32'h0;
      if (bus_rd) begin
        case (bus_addr)
          16'h0000: nd = 32'h0927_2011;
          16'h0004: nd = HZ;
          16'h0008: nd = m_led;
          16'h000C: nd = sync_now;
          default:  nd = 32'h0;
        endcase
      end
      m_req = bus_wr && bus_addr == 16'h0010 && bus_wdata == 32'h0000_DEAD;
      if (bus_wr && bus_addr == 16'h0008) m_led = bus_wdata;
      m_rdata = nd;
      hist.push_back(32'(sw_in));
      if (hist.size() > 2) void'(hist.pop_front());
    end
    #(T/4);
    if (!done) begin
      check({phase, " model rdata R8"}, bus_rdata, m_rdata);
      check({phase, " model led R3"}, led_out, m_led);
      check({phase, " model req R5"}, 32'(sys_rst_req), 32'(m_req));
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(T * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    check("R6 reset rdata", bus_rdata, 0);
    check("R6 reset led", led_out, 0);
    check("R6 reset req", 32'(sys_rst_req), 0);
    rst_n = 1'b1;

    phase = "R1";
    do_read(16'h0000, r); check("R1 id", r, 32'h0927_2011);
    do_write(16'h0000, 32'h1234_5678);
    do_read(16'h0000, r); check("R1 id after write", r, 32'h0927_2011);

    phase = "R2";
    do_read(16'h0004, r); check("R2 freq", r, HZ);
    do_write(16'h0004, 32'h0);
    do_read(16'h0004, r); check("R2 freq after write", r, HZ);

    phase = "R3";
    do_write(16'h0008, 32'hAAAA_5555);
    check("R3 led_out", led_out, 32'hAAAA_5555);
    do_read(16'h0008, r); check("R3 readback", r, 32'hAAAA_5555);
    do_write(16'h0008, 32'hFFFF_FFFF);
    do_read(16'h0008, r); check("R3 readback ones", r, 32'hFFFF_FFFF);

    phase = "R8";
    @(negedge clk);
    bus_addr = 16'h0008; bus_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h0BAD_F00D;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R8 read-with-write old value", bus_rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R8 idle zero", bus_rdata, 0);
    check("R3 led after combined", led_out, 32'h0BAD_F00D);

    phase = "R4";
    sw_in = 12'hA5C;
    repeat (3) @(negedge clk);
    do_read(16'h000C, r); check("R4 switches", r, 32'h0000_0A5C);
    do_write(16'h000C, 32'h0000_0123);
    do_read(16'h000C, r); check("R4 switch write ignored", r, 32'h0000_0A5C);
    check("R4 led untouched", led_out, 32'h0BAD_F00D);

    phase = "R5";
    do_write(16'h0010, 32'h0000_DEAE);
    check("R5 wrong key no pulse", 32'(sys_rst_req), 0);
    do_write(16'h0010, 32'h0001_DEAD);
    check("R5 wide key no pulse", 32'(sys_rst_req), 0);
    do_write(16'h0010, 32'h0000_DEAD);
    check("R5 pulse high", 32'(sys_rst_req), 1);
    @(negedge clk);
    check("R5 pulse one cycle", 32'(sys_rst_req), 0);
    do_write(16'h0014, 32'h0000_DEAD);
    check("R5 key elsewhere no pulse", 32'(sys_rst_req), 0);

    phase = "R7";
    do_read(16'h0010, r); check("R7 cmd reads zero", r, 0);
    do_read(16'h0002, r); check("R7 misaligned zero", r, 0);
    do_read(16'h0014, r); check("R7 gap zero", r, 0);
    do_write(16'h0020, 32'h5A5A_5A5A);
    check("R7 stray write led kept", led_out, 32'h0BAD_F00D);

    phase = "R9";
    do_read(16'h1008, r); check("R9 alias 0x1008 zero", r, 0);
    do_read(16'hFFFC, r); check("R9 top zero", r, 0);
    do_write(16'h1008, 32'h1111_1111);
    check("R9 alias write ignored", led_out, 32'h0BAD_F00D);
    do_write(16'h8010, 32'h0000_DEAD);
    check("R9 alias cmd no pulse", 32'(sys_rst_req), 0);

    phase = "R6";
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6 mid reset led", led_out, 0);
    @(negedge clk); rst_n = 1'b1;
    do_read(16'h000C, r); check("R6 switch cleared", r, 0);
    do_read(16'h0004, r); check("R6 freq kept", r, HZ);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule